// File: doc/BRIEF.md
# Thread-partitioned reorder buffer

This block tracks in-flight micro-ops for a two-thread out-of-order core. Every entry holds one micro-op. The storage is cut into two fixed halves, one per hardware thread. Each half runs as its own circular queue, with an allocate (tail) pointer and a retire (head) pointer. Rename hands each thread a group of up to four micro-ops per cycle. Each micro-op in an accepted group receives a global entry index. Execution later marks that index complete through any of the completion ports.

Retirement is in order within each thread. The four retire slots of a cycle all go to one thread. The slot owner alternates between the threads, and a thread that has nothing ready gives up its turn. Every retired slot shows the entry index and the physical-register tag that was recorded at allocation, so that downstream logic can free the register. A per-thread flush throws away everything that thread has in flight and leaves the other thread's half untouched.

Top module: `rob_tp`

## Requirements
- R1: While reset is held and right after it is released, `retire_valid_o` is all zero and both halves are empty, so a four-wide group is accepted by either thread.
- R2: Thread t owns global indices t*96 to t*96+95. The k-th micro-op of an accepted group gets index t*96 + ((tail + k) mod 96), where tail is the thread's allocate pointer. The next group continues from the first index after the last one handed out, and the indices wrap inside the thread's half.
- R3: `alloc_ready_o[t]` is high only when three conditions hold: the thread's flush is low, `alloc_cnt_i[t]` is at most 4, and the group fits in the free entries of that thread's own half. When ready is low, no entry of the group is taken. One half being full never affects the other half.
- R4: Retirement follows program order within each thread, at up to four entries per cycle. Suppose an entry's completion is applied at clock edge N while all older entries are already complete. That entry then retires at edge N+1. The retire outputs are registered and show the retired group during the cycle after that edge, filling slot 0 upward with no gaps.
- R5: Retirement stops at the oldest entry that is not complete. Younger entries of the same thread do not retire, even when they have completed.
- R6: A cycle's retire slots all belong to the single thread shown on `retire_tid_o` (0 or 1). After a thread retires, the turn passes to the other thread. A thread with no complete entry at its head loses its turn.
- R7: In the cycle that `flush_i[t]` is high, thread t's in-flight entries are discarded and its allocate pointer returns to its retire pointer. That thread neither allocates nor retires in that cycle, and a completion aimed at it in that cycle has no effect. The other thread is not affected.
- R8: A completion aimed at an entry that holds no micro-op, or at an index of 192 or above, is ignored. That entry, if allocated later, still waits for a completion of its own.
- R9: Each valid retire slot carries the global entry index and the physical-register tag that were recorded when the micro-op was allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 2 | Allocation request per thread |
| alloc_cnt_i | input | 2x3 | Number of micro-ops in each thread's group (1 to 4) |
| alloc_preg_i | input | 2x4x8 | Physical-register tag for each micro-op of the group |
| alloc_ready_o | output | 2 | The thread's group fits and would be accepted |
| alloc_idx_o | output | 2x4x8 | Global entry index given to each micro-op of the group |
| cmpl_valid_i | input | 4 | Completion port strobes |
| cmpl_idx_i | input | 4x8 | Global entry index being completed on each port |
| flush_i | input | 2 | Per-thread flush |
| retire_valid_o | output | 4 | Retire slot valid, filled from slot 0 |
| retire_tid_o | output | 1 | Thread that owns this cycle's retire slots |
| retire_idx_o | output | 4x8 | Global index of each retired entry |
| retire_preg_o | output | 4x8 | Physical-register tag released by each retired entry |

## Verification
The ready flag and the assigned indices are combinational functions of the current state and the request. The bench therefore samples them 1 ns after driving the inputs on the falling edge, before the rising edge that would take the group. Completions, allocations and flushes are applied at the rising edge. Retirement is decided from the state between edges and shown on registered outputs. A completion applied at edge N can therefore appear on the retire outputs only after edge N+1. A reference queue model in the bench updates once per rising edge, and the bench compares its predicted retire group at the next falling edge. The directed phases check, at the exact cycle each is due, the full-half rejection, a stalled oldest entry, a completion to an empty entry, the hand-over between the two threads, and the reuse of indices after a flush.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef logic tid_t;

  // modular pointer step, k < depth assumed
  function automatic int unsigned wrap_add(int unsigned p, int unsigned k, int unsigned depth);
    int unsigned s;
    s = p + k;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/rob_thread_q.sv
module rob_thread_q import rob_pkg::*; #(
  parameter int unsigned DEPTH      = 96,
  parameter int unsigned ALLOC_W    = 4,
  parameter int unsigned RETIRE_W   = 4,
  parameter int unsigned CMPL_PORTS = 4,
  parameter int unsigned PREG_W     = 8,
  localparam int unsigned LW  = $clog2(DEPTH),
  localparam int unsigned CW  = $clog2(DEPTH + 1),
  localparam int unsigned ACW = $clog2(ALLOC_W + 1),
  localparam int unsigned RCW = $clog2(RETIRE_W + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              alloc_valid_i,
  input  logic [ACW-1:0]                    alloc_cnt_i,
  input  logic [ALLOC_W-1:0][PREG_W-1:0]    alloc_preg_i,
  output logic                              alloc_ready_o,
  output logic [ALLOC_W-1:0][LW-1:0]        alloc_lidx_o,
  input  logic [CMPL_PORTS-1:0]             cmpl_hit_i,
  input  logic [CMPL_PORTS-1:0][LW-1:0]     cmpl_lidx_i,
  input  logic                              flush_i,
  output logic [RCW-1:0]                    rd_cnt_o,
  output logic [RETIRE_W-1:0][PREG_W-1:0]   rd_preg_o,
  output logic [RETIRE_W-1:0][LW-1:0]       rd_lidx_o,
  input  logic                              retire_go_i,
  output logic [CW-1:0]                     cnt_o
);

  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  done_q;
  logic [PREG_W-1:0] preg_q [DEPTH];
  logic [LW-1:0]     head_q;
  logic [LW-1:0]     tail_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     free_w;
  logic              acc_w;
  logic [RCW-1:0]    rd_cnt_w;
  logic              run_w;

  assign free_w        = CW'(DEPTH) - cnt_q;
  assign alloc_ready_o = !flush_i && (alloc_cnt_i <= ACW'(ALLOC_W)) && (CW'(alloc_cnt_i) <= free_w);
  assign acc_w         = alloc_valid_i && alloc_ready_o;
  assign cnt_o         = cnt_q;
  assign rd_cnt_o      = rd_cnt_w;

  always_comb begin
    for (int k = 0; k < int'(ALLOC_W); k++) begin
      alloc_lidx_o[k] = LW'(wrap_add(tail_q, k, DEPTH));
    end
  end

  // contiguous run of completed entries from the head
  always_comb begin
    run_w    = 1'b1;
    rd_cnt_w = '0;
    for (int k = 0; k < int'(RETIRE_W); k++) begin
      rd_lidx_o[k] = LW'(wrap_add(head_q, k, DEPTH));
      rd_preg_o[k] = preg_q[rd_lidx_o[k]];
      if (run_w && valid_q[rd_lidx_o[k]] && done_q[rd_lidx_o[k]]) begin
        rd_cnt_w = RCW'(k + 1);
      end else begin
        run_w = 1'b0;
      end
    end
    if (flush_i) rd_cnt_w = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      done_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
    end else begin
      for (int p = 0; p < int'(CMPL_PORTS); p++) begin
        if (cmpl_hit_i[p] && valid_q[cmpl_lidx_i[p]]) done_q[cmpl_lidx_i[p]] <= 1'b1;
      end
      if (retire_go_i) begin
        for (int k = 0; k < int'(RETIRE_W); k++) begin
          if (k < int'(rd_cnt_w)) begin
            valid_q[rd_lidx_o[k]] <= 1'b0;
            done_q[rd_lidx_o[k]]  <= 1'b0;
          end
        end
        head_q <= LW'(wrap_add(head_q, rd_cnt_w, DEPTH));
      end
      if (acc_w) begin
        for (int k = 0; k < int'(ALLOC_W); k++) begin
          if (k < int'(alloc_cnt_i)) begin
            valid_q[alloc_lidx_o[k]] <= 1'b1;
            done_q[alloc_lidx_o[k]]  <= 1'b0;
          end
        end
        tail_q <= LW'(wrap_add(tail_q, alloc_cnt_i, DEPTH));
      end
      cnt_q <= cnt_q + (acc_w ? CW'(alloc_cnt_i) : CW'(0))
                     - (retire_go_i ? CW'(rd_cnt_w) : CW'(0));
      if (flush_i) begin
        valid_q <= '0;
        done_q  <= '0;
        tail_q  <= head_q;
        cnt_q   <= '0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (acc_w) begin
      for (int k = 0; k < int'(ALLOC_W); k++) begin
        if (k < int'(alloc_cnt_i)) preg_q[alloc_lidx_o[k]] <= alloc_preg_i[k];
      end
    end
  end

endmodule

// File: rtl/rob_retire_arb.sv
module rob_retire_arb import rob_pkg::*; #(
  parameter int unsigned RCW = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0][RCW-1:0] rd_cnt_i,
  output logic                grant_valid_o,
  output tid_t                grant_tid_o
);

  tid_t turn_q;

  always_comb begin
    if (rd_cnt_i[turn_q] != '0) begin
      grant_valid_o = 1'b1;
      grant_tid_o   = turn_q;
    end else if (rd_cnt_i[!turn_q] != '0) begin
      grant_valid_o = 1'b1;
      grant_tid_o   = !turn_q;
    end else begin
      grant_valid_o = 1'b0;
      grant_tid_o   = turn_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            turn_q <= 1'b0;
    else if (grant_valid_o) turn_q <= !grant_tid_o;
  end

endmodule

// File: rtl/rob_tp.sv
module rob_tp import rob_pkg::*; #(
  parameter int unsigned NUM_ENTRIES = 192,
  parameter int unsigned ALLOC_W     = 4,
  parameter int unsigned RETIRE_W    = 4,
  parameter int unsigned CMPL_PORTS  = 4,
  parameter int unsigned PREG_W      = 8,
  localparam int unsigned PER_THREAD = NUM_ENTRIES / 2,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
  localparam int unsigned LW         = $clog2(PER_THREAD),
  localparam int unsigned CW         = $clog2(PER_THREAD + 1),
  localparam int unsigned ACW        = $clog2(ALLOC_W + 1),
  localparam int unsigned RCW        = $clog2(RETIRE_W + 1)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [1:0]                            alloc_valid_i,
  input  logic [1:0][ACW-1:0]                   alloc_cnt_i,
  input  logic [1:0][ALLOC_W-1:0][PREG_W-1:0]   alloc_preg_i,
  output logic [1:0]                            alloc_ready_o,
  output logic [1:0][ALLOC_W-1:0][IDX_W-1:0]    alloc_idx_o,
  input  logic [CMPL_PORTS-1:0]                 cmpl_valid_i,
  input  logic [CMPL_PORTS-1:0][IDX_W-1:0]      cmpl_idx_i,
  input  logic [1:0]                            flush_i,
  output logic [RETIRE_W-1:0]                   retire_valid_o,
  output logic                                  retire_tid_o,
  output logic [RETIRE_W-1:0][IDX_W-1:0]        retire_idx_o,
  output logic [RETIRE_W-1:0][PREG_W-1:0]       retire_preg_o
);

  logic [1:0][CMPL_PORTS-1:0]           cmpl_hit;
  logic [CMPL_PORTS-1:0][LW-1:0]        cmpl_lidx;
  logic [1:0][ALLOC_W-1:0][LW-1:0]      q_alloc_lidx;
  logic [1:0][RCW-1:0]                  q_rd_cnt;
  logic [1:0][RETIRE_W-1:0][PREG_W-1:0] q_rd_preg;
  logic [1:0][RETIRE_W-1:0][LW-1:0]     q_rd_lidx;
  logic [1:0][CW-1:0]                   q_cnt;
  logic [1:0]                           retire_go;
  logic                                 gnt_valid;
  tid_t                                 gnt_tid;

  // completion index decode into thread and local slot
  for (genvar p = 0; p < CMPL_PORTS; p++) begin : g_cmpl
    logic in_rng, upper;
    assign in_rng       = cmpl_idx_i[p] < IDX_W'(NUM_ENTRIES);
    assign upper        = cmpl_idx_i[p] >= IDX_W'(PER_THREAD);
    assign cmpl_lidx[p] = upper ? LW'(cmpl_idx_i[p] - IDX_W'(PER_THREAD)) : LW'(cmpl_idx_i[p]);
    assign cmpl_hit[0][p] = cmpl_valid_i[p] && in_rng && !upper;
    assign cmpl_hit[1][p] = cmpl_valid_i[p] && in_rng && upper;
  end

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assign retire_go[t] = gnt_valid && (gnt_tid == tid_t'(t));

    rob_thread_q #(
      .DEPTH      (PER_THREAD),
      .ALLOC_W    (ALLOC_W),
      .RETIRE_W   (RETIRE_W),
      .CMPL_PORTS (CMPL_PORTS),
      .PREG_W     (PREG_W)
    ) u_q (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .alloc_valid_i (alloc_valid_i[t]),
      .alloc_cnt_i   (alloc_cnt_i[t]),
      .alloc_preg_i  (alloc_preg_i[t]),
      .alloc_ready_o (alloc_ready_o[t]),
      .alloc_lidx_o  (q_alloc_lidx[t]),
      .cmpl_hit_i    (cmpl_hit[t]),
      .cmpl_lidx_i   (cmpl_lidx),
      .flush_i       (flush_i[t]),
      .rd_cnt_o      (q_rd_cnt[t]),
      .rd_preg_o     (q_rd_preg[t]),
      .rd_lidx_o     (q_rd_lidx[t]),
      .retire_go_i   (retire_go[t]),
      .cnt_o         (q_cnt[t])
    );

    for (genvar k = 0; k < ALLOC_W; k++) begin : g_aidx
      assign alloc_idx_o[t][k] = IDX_W'(t * PER_THREAD) + IDX_W'(q_alloc_lidx[t][k]);
    end
  end

  rob_retire_arb #(.RCW(RCW)) u_arb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_cnt_i      (q_rd_cnt),
    .grant_valid_o (gnt_valid),
    .grant_tid_o   (gnt_tid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retire_valid_o <= '0;
      retire_tid_o   <= 1'b0;
      retire_idx_o   <= '0;
      retire_preg_o  <= '0;
    end else begin
      retire_tid_o <= gnt_tid;
      for (int k = 0; k < int'(RETIRE_W); k++) begin
        retire_valid_o[k] <= gnt_valid && (k < int'(q_rd_cnt[gnt_tid]));
        retire_preg_o[k]  <= q_rd_preg[gnt_tid][k];
        retire_idx_o[k]   <= (gnt_tid ? IDX_W'(PER_THREAD) : IDX_W'(0))
                             + IDX_W'(q_rd_lidx[gnt_tid][k]);
      end
    end
  end

endmodule

// File: rtl/rob_tp_chk.sv
module rob_tp_chk #(
  parameter int unsigned PER_THREAD = 96,
  parameter int unsigned RETIRE_W   = 4,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned CW         = 7,
  parameter int unsigned RCW        = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [1:0]                   flush_i,
  input logic [RETIRE_W-1:0]          retire_valid_i,
  input logic                         retire_tid_i,
  input logic [RETIRE_W-1:0][IDX_W-1:0] retire_idx_i,
  input logic [1:0][CW-1:0]           q_cnt_i,
  input logic [1:0][RCW-1:0]          q_rd_cnt_i
);

  logic any_ret;
  assign any_ret = |retire_valid_i;

  for (genvar k = 0; k + 1 < RETIRE_W; k++) begin : g_pack
    AST_RETIRE_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      retire_valid_i[k+1] |-> retire_valid_i[k]); // R4
  end

  for (genvar k = 0; k < RETIRE_W; k++) begin : g_half
    AST_RETIRE_IN_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      retire_valid_i[k] |-> (((retire_idx_i[k] >= IDX_W'(PER_THREAD)) == retire_tid_i)
                             && (retire_idx_i[k] < IDX_W'(2 * PER_THREAD)))); // R9
  end

  for (genvar t = 0; t < 2; t++) begin : g_thr
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_cnt_i[t] <= CW'(PER_THREAD)); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i[t] |=> (q_cnt_i[t] == '0)); // R7
    AST_FLUSH_NO_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i[t] |=> !(any_ret && (retire_tid_i == 1'(t)))); // R7
    AST_TURN_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_ret && $past(any_ret) && (retire_tid_i == 1'(t)) && ($past(retire_tid_i) == 1'(t)))
      |-> $past(q_rd_cnt_i[1-t] == '0)); // R6
  end

endmodule

bind rob_tp rob_tp_chk #(
  .PER_THREAD (PER_THREAD),
  .RETIRE_W   (RETIRE_W),
  .IDX_W      (IDX_W),
  .CW         (CW),
  .RCW        (RCW)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flush_i        (flush_i),
  .retire_valid_i (retire_valid_o),
  .retire_tid_i   (retire_tid_o),
  .retire_idx_i   (retire_idx_o),
  .q_cnt_i        (q_cnt),
  .q_rd_cnt_i     (q_rd_cnt)
);

// File: tb/tb_rob_tp.sv
module tb_rob_tp;
  localparam int NE = 192, PT = 96, AW = 4, RW = 4, CP = 4, PW = 8, IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]                alloc_valid;
  logic [1:0][2:0]           alloc_cnt;
  logic [1:0][AW-1:0][PW-1:0] alloc_preg;
  logic [1:0]                alloc_ready;
  logic [1:0][AW-1:0][IW-1:0] alloc_idx;
  logic [CP-1:0]             cmpl_valid;
  logic [CP-1:0][IW-1:0]     cmpl_idx;
  logic [1:0]                flush;
  logic [RW-1:0]             retire_valid;
  logic                      retire_tid;
  logic [RW-1:0][IW-1:0]     retire_idx;
  logic [RW-1:0][PW-1:0]     retire_preg;

  rob_tp #(.NUM_ENTRIES(NE), .ALLOC_W(AW), .RETIRE_W(RW), .CMPL_PORTS(CP), .PREG_W(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_cnt_i(alloc_cnt), .alloc_preg_i(alloc_preg),
    .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx),
    .cmpl_valid_i(cmpl_valid), .cmpl_idx_i(cmpl_idx), .flush_i(flush),
    .retire_valid_o(retire_valid), .retire_tid_o(retire_tid),
    .retire_idx_o(retire_idx), .retire_preg_o(retire_preg)
  );

  // reference queues
  bit   mv [2][PT];
  bit   md [2][PT];
  int   mp [2][PT];
  int   mh [2];
  int   mc [2];
  int   mturn;
  bit   ev [RW];
  int   etid;
  int   eidx [RW];
  int   epreg [RW];

  int    checks = 0;
  int    errs = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_idle();
    alloc_valid = '0; alloc_cnt = '0; alloc_preg = '0;
    cmpl_valid = '0; cmpl_idx = '0; flush = '0;
  endtask

  function automatic bit fits(int t);
    return !flush[t] && (alloc_cnt[t] <= AW) && (int'(alloc_cnt[t]) <= PT - mc[t]);
  endfunction

  // one rising edge of the expected behaviour
  task automatic model_edge();
    int rc [2];
    int tl [2];
    bit acc [2];
    int g;
    bit gv;
    for (int t = 0; t < 2; t++) begin
      rc[t] = 0;
      if (!flush[t]) begin
        for (int k = 0; k < RW; k++) begin
          int l;
          l = (mh[t] + k) % PT;
          if (rc[t] == k && mv[t][l] && md[t][l]) rc[t] = k + 1;
        end
      end
      acc[t] = alloc_valid[t] && fits(t);
      tl[t]  = (mh[t] + mc[t]) % PT;
    end
    gv = 1'b0; g = mturn;
    if (rc[mturn] > 0) gv = 1'b1;
    else if (rc[1-mturn] > 0) begin gv = 1'b1; g = 1 - mturn; end
    etid = g;
    for (int k = 0; k < RW; k++) begin
      ev[k]    = gv && (k < rc[g]);
      eidx[k]  = g * PT + (mh[g] + k) % PT;
      epreg[k] = mp[g][(mh[g] + k) % PT];
    end
    for (int p = 0; p < CP; p++) begin
      if (cmpl_valid[p] && cmpl_idx[p] < NE) begin
        int t, l;
        t = cmpl_idx[p] / PT; l = cmpl_idx[p] % PT;
        if (mv[t][l]) md[t][l] = 1'b1;
      end
    end
    if (gv) begin
      for (int k = 0; k < rc[g]; k++) begin
        mv[g][(mh[g] + k) % PT] = 1'b0;
        md[g][(mh[g] + k) % PT] = 1'b0;
      end
      mh[g] = (mh[g] + rc[g]) % PT;
      mc[g] = mc[g] - rc[g];
      mturn = 1 - g;
    end
    for (int t = 0; t < 2; t++) begin
      if (acc[t]) begin
        for (int k = 0; k < int'(alloc_cnt[t]); k++) begin
          mv[t][(tl[t] + k) % PT] = 1'b1;
          md[t][(tl[t] + k) % PT] = 1'b0;
          mp[t][(tl[t] + k) % PT] = alloc_preg[t][k];
        end
        mc[t] = mc[t] + alloc_cnt[t];
      end
      if (flush[t]) begin
        for (int l = 0; l < PT; l++) begin mv[t][l] = 1'b0; md[t][l] = 1'b0; end
        mc[t] = 0;
      end
    end
  endtask

  // inputs are set at a falling edge before calling
  task automatic step();
    #1;
    for (int t = 0; t < 2; t++) begin
      chk(flush[t] ? "R7" : "R3", alloc_ready[t], fits(t));
      if (alloc_valid[t] && fits(t)) begin
        int tl;
        tl = (mh[t] + mc[t]) % PT;
        for (int k = 0; k < int'(alloc_cnt[t]); k++)
          chk("R2", alloc_idx[t][k], t * PT + (tl + k) % PT);
      end
    end
    model_edge();
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < RW; k++) begin
      chk(cur_tag, retire_valid[k], ev[k]);
      if (ev[k]) begin
        chk("R9", retire_idx[k], eidx[k]);
        chk("R9", retire_preg[k], epreg[k]);
      end
    end
    if (ev[0]) chk(cur_tag, retire_tid, etid);
    set_idle();
  endtask

  task automatic alloc_grp(int t, int n);
    alloc_valid[t] = 1'b1;
    alloc_cnt[t]   = 3'(n);
    for (int k = 0; k < AW; k++) alloc_preg[t][k] = PW'($urandom);
  endtask

  task automatic cmpl(int p, int idx);
    cmpl_valid[p] = 1'b1;
    cmpl_idx[p]   = IW'(idx);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    set_idle();
    for (int t = 0; t < 2; t++) begin
      mh[t] = 0; mc[t] = 0;
      for (int l = 0; l < PT; l++) begin mv[t][l] = 0; md[t][l] = 0; mp[t][l] = 0; end
    end
    mturn = 0;
    repeat (3) @(negedge clk);
    chk("R1", retire_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    alloc_cnt[0] = 3'd4; alloc_cnt[1] = 3'd4;
    #1;
    chk("R1", alloc_ready[0], 1);
    chk("R1", alloc_ready[1], 1);
    chk("R1", retire_valid, 0);
    set_idle();
    @(negedge clk);

    // fill thread 0 half completely
    cur_tag = "R2";
    for (int i = 0; i < PT / AW; i++) begin alloc_grp(0, 4); step(); end
    alloc_grp(0, 1); alloc_cnt[1] = 3'd4;
    #1;
    chk("R3", alloc_ready[0], 0);
    chk("R3", alloc_ready[1], 1);
    step();

    // oldest entry blocks younger completed ones
    cur_tag = "R5";
    cmpl(0, 1); cmpl(1, 2); cmpl(2, 3);
    step();
    repeat (3) begin step(); chk("R5", retire_valid, 0); end
    cmpl(0, 0);
    step();
    step();
    chk("R5", $countones(retire_valid), 4);

    // completion to an empty entry and to an out-of-range index
    cur_tag = "R8";
    cmpl(0, 96); cmpl(1, 250);
    step();
    alloc_grp(1, 4);
    step();
    repeat (3) step();
    chk("R8", retire_valid, 0);

    // both threads ready at once: turn hand-over
    cur_tag = "R6";
    cmpl(0, 5); cmpl(1, 6); cmpl(2, 7); cmpl(3, 97);
    step();
    cmpl(0, 8); cmpl(1, 9); cmpl(2, 10); cmpl(3, 11);
    step();
    cmpl(0, 98); cmpl(1, 99); cmpl(2, 4); cmpl(3, 96);
    step();
    step();
    chk("R6", retire_tid, 1);
    chk("R6", $countones(retire_valid), 4);
    step();
    chk("R6", retire_tid, 0);
    chk("R6", retire_idx[0], 4);
    step();
    chk("R6", retire_tid, 0);
    chk("R6", retire_idx[0], 8);

    // flush of thread 0 while thread 1 keeps working
    cur_tag = "R7";
    alloc_grp(1, 4);
    step();
    cmpl(0, 100); cmpl(1, 101);
    step();
    flush[0] = 1'b1; cmpl(0, 12);
    step();
    alloc_grp(0, 4);
    #1;
    chk("R7", alloc_ready[0], 1);
    chk("R7", alloc_idx[0][0], 12);
    step();
    cmpl(0, 12);
    step();
    step();
    chk("R7", retire_idx[0], 12);

    // random traffic
    cur_tag = "R4";
    repeat (4000) begin
      for (int t = 0; t < 2; t++) begin
        if ($urandom % 2 == 0) alloc_grp(t, 1 + int'($urandom % 4));
        flush[t] = ($urandom % 100 == 0);
      end
      for (int p = 0; p < CP; p++) begin
        if ($urandom % 4 != 0) begin
          int t;
          t = int'($urandom % 2);
          if (mc[t] > 0) cmpl(p, t * PT + (mh[t] + int'($urandom % mc[t])) % PT);
          else cmpl(p, int'($urandom % 256));
        end
      end
      step();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

endmodule